// File: doc/BRIEF.md
# I2C Peripheral Control Register

This block is the software-visible control register of an I2C peripheral that can act as master or slave. It holds six control bits: peripheral enable, general-call enable, START request, acknowledge enable, STOP request and interrupt enable. It applies the hardware set and clear rules to those bits. It also keeps the clock-range field and the 10-bit addressing flag, and refuses writes to them while the peripheral runs. Software reaches all three registers over a simple synchronous bus. The write strobe is sampled on the rising clock edge, and the read data is combinational on the address. The bit-level bus engine runs alongside the block. It reports when a start condition has gone out, when a stop condition has gone out, whether a byte transfer has finished, and whether it is master or slave. It receives the request bits in return, together with a line-release request, the pin-select and a hold-clear for its status flags.

An enable state machine has three states. `EN_OFF` is the peripheral disabled. `EN_ARMED` is enabled after the first write, which only switched it on. `EN_LIVE` is enabled after a later write has loaded the remaining bits. These transitions are defined:
- A control write with enable=1 moves `EN_OFF` to `EN_ARMED`.
- A control write with enable=1 moves `EN_ARMED` to `EN_LIVE`.
- A control write with enable=0 moves `EN_ARMED` or `EN_LIVE` back to `EN_OFF`.
- Every other cycle holds the present state.

Top module: `i2c_ctl_regs`

## Requirements
- R1: After reset, every register reads 00h. Address 0 is the control register, laid out from bit 5 down to bit 0 as enable, general-call enable, START, ACK, STOP, interrupt enable. Bits 7:6 of the control register always read zero. Address 1 is the configuration register, and address 2 reads the interrupt flag in bit 0.
- R2: A control write with bit 5 set while disabled sets only the enable bit. Every other written bit is ignored. A later write with bit 5 set loads all the bits.
- R3: While disabled, the general-call enable, START, ACK and interrupt-enable bits are held at zero. The interrupt flag is also held at zero, and the status hold-clear output is high.
- R4: A control write that disables the peripheral leaves STOP at its previous value.
- R5: While disabled, the pin-select output and the STOP request to the engine are both low. While enabled, the pin-select output is high.
- R6: Configuration register bits 2:0 hold the clock range and bit 3 holds the 10-bit-address flag. A write to the configuration register takes effect only while disabled. While enabled, such a write is discarded.
- R7: START is cleared in the cycle after the engine reports a start sent. In that cycle, the hardware clear wins over a software write that sets START.
- R8: The interrupt flag goes high after a reported start sent, provided interrupt enable is set. It stays high until software writes 1 to bit 0 of address 2.
- R9: In master mode, STOP is cleared after the engine reports a stop sent. The hardware clear wins over a write in the same cycle.
- R10: In slave mode, hardware never clears STOP. A write that sets STOP takes effect only while the byte-transfer-finished input is high, and a write with STOP=0 clears it. While STOP is set in slave mode, the line-release output is high.
- R11: A control write with bit 5 clear while disabled changes no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| is_master | input | 1 | Engine is in master mode |
| ev_start_sent | input | 1 | Pulse: start condition sent |
| ev_stop_sent | input | 1 | Pulse: stop condition sent |
| ev_byte_done | input | 1 | Byte-transfer-finished flag |
| pin_altfn | output | 1 | Select open-drain alternate function on the pins |
| ctl_gcall | output | 1 | General-call enable to engine |
| ctl_start | output | 1 | START request |
| ctl_ack | output | 1 | Acknowledge enable |
| ctl_stop | output | 1 | STOP request (gated by enable) |
| ctl_irq_en | output | 1 | Interrupt enable |
| lines_release | output | 1 | Slave request to release SCL and SDA |
| irq | output | 1 | Interrupt request level |
| stat_hold_clr | output | 1 | Hold status flags cleared |
| cfg_clk_range | output | 3 | Clock-range field |
| cfg_addr10 | output | 1 | 10-bit addressing flag |

## Verification
The hardest state to reach from the ports is a STOP bit that is set while the peripheral is disabled. Reaching it requires a two-write enable, setting STOP in master mode, and then a disabling write. After that, the bench checks that the bit survives the disable and the ignored writes that follow, and that a re-enable shows it again. Same-cycle collisions, such as a software write of START together with a reported start sent, are driven directly. Seeded random cycles then mix mode changes, event pulses and writes to all addresses against a bench model.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;

    typedef enum logic [1:0] {
        EN_OFF   = 2'd0,
        EN_ARMED = 2'd1,
        EN_LIVE  = 2'd2
    } en_state_t;

    localparam int BIT_EN    = 5;
    localparam int BIT_GC    = 4;
    localparam int BIT_START = 3;
    localparam int BIT_ACK   = 2;
    localparam int BIT_STOP  = 1;
    localparam int BIT_IE    = 0;

    localparam int A_CTL = 0;
    localparam int A_CFG = 1;
    localparam int A_IRQ = 2;

    typedef struct packed {
        logic gc;
        logic start;
        logic ack;
        logic stop;
        logic ie;
    } ctl_bits_t;

endpackage

// File: rtl/i2c_ctl_enfsm.sv
module i2c_ctl_enfsm
    import i2c_ctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctl_wr,
    input  logic      wr_en_bit,
    output en_state_t state_o,
    output logic      en_now,
    output logic      en_nxt
);

    en_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EN_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EN_OFF: begin
                if (ctl_wr && wr_en_bit) state_d = EN_ARMED;
            end
            EN_ARMED: begin
                if (ctl_wr) state_d = wr_en_bit ? EN_LIVE : EN_OFF;
            end
            EN_LIVE: begin
                if (ctl_wr && !wr_en_bit) state_d = EN_OFF;
            end
            default: state_d = EN_OFF;
        endcase
    end

    always_comb begin
        state_o = state_q;
        en_now  = (state_q != EN_OFF);
        en_nxt  = (state_d != EN_OFF);
    end

endmodule

// File: rtl/i2c_ctl_bits.sv
module i2c_ctl_bits
    import i2c_ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_now,
    input  logic            en_nxt,
    input  logic            ctl_wr,
    input  logic [BIT_EN:0] wd,
    input  logic            is_master,
    input  logic            start_sent,
    input  logic            stop_sent,
    input  logic            byte_done,
    input  logic            irq_clr,
    output ctl_bits_t       bits_q,
    output logic            irq_q
);

    logic load;
    logic start_hw_clr;
    logic stop_hw_clr;
    logic stop_wr_val;
    logic irq_set;

    always_comb begin
        load         = ctl_wr && en_now && en_nxt;
        start_hw_clr = en_now && start_sent;
        stop_hw_clr  = en_now && is_master && stop_sent;
        irq_set      = en_now && start_sent && bits_q.ie;
        if (is_master)        stop_wr_val = wd[BIT_STOP];
        else if (wd[BIT_STOP]) stop_wr_val = byte_done ? 1'b1 : bits_q.stop;
        else                   stop_wr_val = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (!en_nxt) begin
                bits_q.gc  <= 1'b0;
                bits_q.ack <= 1'b0;
                bits_q.ie  <= 1'b0;
            end else if (load) begin
                bits_q.gc  <= wd[BIT_GC];
                bits_q.ack <= wd[BIT_ACK];
                bits_q.ie  <= wd[BIT_IE];
            end

            if (!en_nxt || start_hw_clr) bits_q.start <= 1'b0;
            else if (load)               bits_q.start <= wd[BIT_START];

            if (stop_hw_clr) bits_q.stop <= 1'b0;
            else if (load)   bits_q.stop <= stop_wr_val;

            if (!en_nxt)      irq_q <= 1'b0;
            else if (irq_set) irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/i2c_ctl_cfg.sv
module i2c_ctl_cfg #(
    parameter int RANGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_now,
    input  logic               cfg_wr,
    input  logic [RANGE_W:0]   wd,
    output logic [RANGE_W-1:0] range_q,
    output logic               addr10_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            range_q  <= '0;
            addr10_q <= 1'b0;
        end else if (cfg_wr && !en_now) begin
            range_q  <= wd[RANGE_W-1:0];
            addr10_q <= wd[RANGE_W];
        end
    end

endmodule

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
    import i2c_ctl_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 8,
    parameter int RANGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               is_master,
    input  logic               ev_start_sent,
    input  logic               ev_stop_sent,
    input  logic               ev_byte_done,
    output logic               pin_altfn,
    output logic               ctl_gcall,
    output logic               ctl_start,
    output logic               ctl_ack,
    output logic               ctl_stop,
    output logic               ctl_irq_en,
    output logic               lines_release,
    output logic               irq,
    output logic               stat_hold_clr,
    output logic [RANGE_W-1:0] cfg_clk_range,
    output logic               cfg_addr10
);

    localparam int CFG_W = RANGE_W + 1;

    logic      wr_ctl, wr_cfg, wr_irq;
    logic      en_now, en_nxt;
    en_state_t en_state;
    ctl_bits_t bits;
    logic      irq_q;
    logic      stop_raw;
    logic      unused_wbits;

    assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign wr_cfg = bus_wr && (bus_addr == ADDR_W'(A_CFG));
    assign wr_irq = bus_wr && (bus_addr == ADDR_W'(A_IRQ)) && bus_wdata[0];
    assign unused_wbits = ^{bus_wdata[DATA_W-1:BIT_EN+1], en_state};

    i2c_ctl_enfsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (wr_ctl),
        .wr_en_bit (bus_wdata[BIT_EN]),
        .state_o   (en_state),
        .en_now    (en_now),
        .en_nxt    (en_nxt)
    );

    i2c_ctl_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_now     (en_now),
        .en_nxt     (en_nxt),
        .ctl_wr     (wr_ctl),
        .wd         (bus_wdata[BIT_EN:0]),
        .is_master  (is_master),
        .start_sent (ev_start_sent),
        .stop_sent  (ev_stop_sent),
        .byte_done  (ev_byte_done),
        .irq_clr    (wr_irq),
        .bits_q     (bits),
        .irq_q      (irq_q)
    );

    i2c_ctl_cfg #(.RANGE_W(RANGE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_now   (en_now),
        .cfg_wr   (wr_cfg),
        .wd       (bus_wdata[CFG_W-1:0]),
        .range_q  (cfg_clk_range),
        .addr10_q (cfg_addr10)
    );

    assign stop_raw = bits.stop;

    always_comb begin
        pin_altfn     = en_now;
        stat_hold_clr = !en_now;
        ctl_gcall     = bits.gc;
        ctl_start     = bits.start;
        ctl_ack       = bits.ack;
        ctl_irq_en    = bits.ie;
        ctl_stop      = en_now && bits.stop;
        lines_release = en_now && !is_master && bits.stop;
        irq           = irq_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CTL)) begin
            bus_rdata[BIT_EN]    = en_now;
            bus_rdata[BIT_GC]    = bits.gc;
            bus_rdata[BIT_START] = bits.start;
            bus_rdata[BIT_ACK]   = bits.ack;
            bus_rdata[BIT_STOP]  = bits.stop;
            bus_rdata[BIT_IE]    = bits.ie;
        end else if (bus_addr == ADDR_W'(A_CFG)) begin
            bus_rdata[CFG_W-1:0] = {cfg_addr10, cfg_clk_range};
        end else if (bus_addr == ADDR_W'(A_IRQ)) begin
            bus_rdata[0] = irq_q;
        end
    end

endmodule

// File: rtl/i2c_ctl_chk.sv
module i2c_ctl_chk
    import i2c_ctl_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int DATA_W  = 8,
    parameter int RANGE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic               is_master,
    input logic               ev_start_sent,
    input logic               ev_stop_sent,
    input logic               ev_byte_done,
    input logic               pin_altfn,
    input logic               ctl_gcall,
    input logic               ctl_start,
    input logic               ctl_ack,
    input logic               ctl_irq_en,
    input logic               stop_raw,
    input logic               irq,
    input logic [RANGE_W-1:0] cfg_clk_range,
    input logic               cfg_addr10
);

    logic wr_ctl;
    logic wr_irq_any;
    assign wr_ctl     = bus_wr && (bus_addr == ADDR_W'(A_CTL));
    assign wr_irq_any = bus_wr && (bus_addr == ADDR_W'(A_IRQ) || bus_addr == ADDR_W'(A_CTL));

    p_first_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_altfn && wr_ctl && bus_wdata[BIT_EN]) |=>
        (pin_altfn && !ctl_gcall && !ctl_start && !ctl_ack && !ctl_irq_en && $stable(stop_raw)));

    p_off_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_altfn |-> (!ctl_gcall && !ctl_start && !ctl_ack && !ctl_irq_en && !irq));

    p_stop_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_altfn && wr_ctl && !bus_wdata[BIT_EN] && !(is_master && ev_stop_sent)) |=>
        $stable(stop_raw));

    p_cfg_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_altfn |=> $stable({cfg_addr10, cfg_clk_range}));

    p_start_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_altfn && ev_start_sent) |=> !ctl_start);

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_altfn && ev_start_sent && ctl_irq_en && !(wr_ctl && !bus_wdata[BIT_EN])) |=> irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_irq_any) |=> irq);

    p_master_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_altfn && is_master && ev_stop_sent) |=> !stop_raw);

    p_slave_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !ev_byte_done && !stop_raw) |=> !stop_raw);

    p_off_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_altfn && wr_ctl && !bus_wdata[BIT_EN]) |=> (!pin_altfn && $stable(stop_raw)));

endmodule

bind i2c_ctl_regs i2c_ctl_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .RANGE_W (RANGE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .is_master     (is_master),
    .ev_start_sent (ev_start_sent),
    .ev_stop_sent  (ev_stop_sent),
    .ev_byte_done  (ev_byte_done),
    .pin_altfn     (pin_altfn),
    .ctl_gcall     (ctl_gcall),
    .ctl_start     (ctl_start),
    .ctl_ack       (ctl_ack),
    .ctl_irq_en    (ctl_irq_en),
    .stop_raw      (stop_raw),
    .irq           (irq),
    .cfg_clk_range (cfg_clk_range),
    .cfg_addr10    (cfg_addr10)
);

// File: tb/sim_i2c_ctl_regs.sv
`timescale 1ns/1ps
module sim_i2c_ctl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       is_master = 1'b1;
    logic       ev_start_sent = 1'b0;
    logic       ev_stop_sent = 1'b0;
    logic       ev_byte_done = 1'b0;
    logic       pin_altfn, ctl_gcall, ctl_start, ctl_ack, ctl_stop, ctl_irq_en;
    logic       lines_release, irq, stat_hold_clr, cfg_addr10;
    logic [2:0] cfg_clk_range;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic m_en, m_gc, m_st, m_ack, m_stop, m_ie, m_irq;
    logic [3:0] m_cfg;

    always #10 clk = ~clk;

    i2c_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .is_master(is_master),
        .ev_start_sent(ev_start_sent), .ev_stop_sent(ev_stop_sent),
        .ev_byte_done(ev_byte_done), .pin_altfn(pin_altfn), .ctl_gcall(ctl_gcall),
        .ctl_start(ctl_start), .ctl_ack(ctl_ack), .ctl_stop(ctl_stop),
        .ctl_irq_en(ctl_irq_en), .lines_release(lines_release), .irq(irq),
        .stat_hold_clr(stat_hold_clr), .cfg_clk_range(cfg_clk_range),
        .cfg_addr10(cfg_addr10)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return {2'b00, m_en, m_gc, m_st, m_ack, m_stop, m_ie};
            2'd1:    return {4'b0000, m_cfg};
            2'd2:    return {7'b0, m_irq};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        {m_en, m_gc, m_st, m_ack, m_stop, m_ie, m_irq} = '0;
        m_cfg = '0;
    endtask

    task automatic model_step(input logic [1:0] a, input logic w, input logic [7:0] d,
                              input logic ms, input logic ss, input logic ps, input logic bd);
        logic cw, nen, ld, nstop;
        cw  = w && (a == 2'd0);
        nen = cw ? d[5] : m_en;
        ld  = cw && m_en && d[5];
        if (m_en && ms && ps)      nstop = 1'b0;
        else if (!ld)              nstop = m_stop;
        else if (ms)               nstop = d[1];
        else if (d[1])             nstop = bd ? 1'b1 : m_stop;
        else                       nstop = 1'b0;
        if (w && a == 2'd1 && !m_en) m_cfg = d[3:0];
        if (!nen)                       m_irq = 1'b0;
        else if (m_en && ss && m_ie)    m_irq = 1'b1;
        else if (w && a == 2'd2 && d[0]) m_irq = 1'b0;
        if (!nen || (m_en && ss)) m_st = 1'b0;
        else if (ld)              m_st = d[3];
        if (!nen) begin
            m_gc = 0; m_ack = 0; m_ie = 0;
        end else if (ld) begin
            m_gc = d[4]; m_ack = d[2]; m_ie = d[0];
        end
        m_stop = nstop;
        m_en   = nen;
    endtask

    task automatic compare_all();
        chk("R5 pin select", {7'b0, pin_altfn}, {7'b0, m_en});
        chk("R5 stop request", {7'b0, ctl_stop}, {7'b0, m_en & m_stop});
        chk("R3 general call", {7'b0, ctl_gcall}, {7'b0, m_gc});
        chk("R7 start", {7'b0, ctl_start}, {7'b0, m_st});
        chk("R3 ack", {7'b0, ctl_ack}, {7'b0, m_ack});
        chk("R3 irq enable", {7'b0, ctl_irq_en}, {7'b0, m_ie});
        chk("R3 hold clear", {7'b0, stat_hold_clr}, {7'b0, !m_en});
        chk("R8 irq", {7'b0, irq}, {7'b0, m_irq});
        chk("R10 release", {7'b0, lines_release}, {7'b0, m_en & !is_master & m_stop});
        chk("R6 config", {4'b0, cfg_addr10, cfg_clk_range}, {4'b0, m_cfg});
        chk("R1 read data", bus_rdata, model_read(bus_addr));
    endtask

    task automatic step(input logic [1:0] a, input logic w, input logic [7:0] d,
                        input logic ms, input logic ss, input logic ps, input logic bd);
        bus_addr = a; bus_wr = w; bus_wdata = d; is_master = ms;
        ev_start_sent = ss; ev_stop_sent = ps; ev_byte_done = bd;
        @(posedge clk);
        model_step(a, w, d, ms, ss, ps, bd);
        #2;
        bus_wr = 0; ev_start_sent = 0; ev_stop_sent = 0;
        compare_all();
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a; bus_wr = 0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset values
        rd(2'd0, 8'h00, "R1 ctl reset");
        rd(2'd1, 8'h00, "R1 cfg reset");
        rd(2'd2, 8'h00, "R1 irq reset");
        // R6 config writable while off
        step(2'd1, 1, 8'h0D, 1, 0, 0, 0);
        rd(2'd1, 8'h0D, "R6 cfg write off");
        // R2 first enable write
        step(2'd0, 1, 8'hFF, 1, 0, 0, 0);
        rd(2'd0, 8'h20, "R2 first write only enable");
        // R6 locked
        step(2'd1, 1, 8'h02, 1, 0, 0, 0);
        rd(2'd1, 8'h0D, "R6 cfg locked");
        // R2 second write loads
        step(2'd0, 1, 8'h3D, 1, 0, 0, 0);
        rd(2'd0, 8'h3D, "R2 second write loads");
        // R7 / R8 start sent
        step(2'd0, 0, 8'h00, 1, 1, 0, 0);
        rd(2'd0, 8'h35, "R7 start cleared");
        rd(2'd2, 8'h01, "R8 irq raised");
        step(2'd3, 0, 8'h00, 1, 0, 0, 0);
        rd(2'd2, 8'h01, "R8 irq held");
        step(2'd2, 1, 8'h01, 1, 0, 0, 0);
        rd(2'd2, 8'h00, "R8 irq cleared");
        // R7 collision
        step(2'd0, 1, 8'h2C, 1, 1, 0, 0);
        rd(2'd0, 8'h24, "R7 hw clear wins");
        // R9 master stop clear, collision
        step(2'd0, 1, 8'h22, 1, 0, 1, 0);
        rd(2'd0, 8'h20, "R9 hw clear wins");
        step(2'd0, 1, 8'h22, 1, 0, 0, 0);
        step(2'd0, 0, 8'h00, 1, 0, 1, 0);
        rd(2'd0, 8'h20, "R9 master stop cleared");
        // R4 stop kept on disable
        step(2'd0, 1, 8'h37, 1, 0, 0, 0);
        step(2'd0, 1, 8'h00, 1, 0, 0, 0);
        rd(2'd0, 8'h02, "R4 stop kept");
        chk("R5 pins released", {6'b0, pin_altfn, ctl_stop}, 8'h00);
        // R11 ignored write while off
        step(2'd0, 1, 8'h1F, 1, 0, 0, 0);
        rd(2'd0, 8'h02, "R11 off write ignored");
        step(2'd0, 1, 8'h20, 0, 0, 0, 0);
        rd(2'd0, 8'h22, "R4 stop visible after enable");
        // R10 slave rules
        step(2'd0, 1, 8'h20, 0, 0, 0, 0);
        rd(2'd0, 8'h20, "R10 slave sw clear");
        step(2'd0, 1, 8'h22, 0, 0, 0, 0);
        rd(2'd0, 8'h20, "R10 slave set blocked");
        step(2'd0, 1, 8'h22, 0, 0, 0, 1);
        rd(2'd0, 8'h22, "R10 slave set with byte done");
        chk("R10 release high", {7'b0, lines_release}, 8'h01);
        step(2'd0, 0, 8'h00, 0, 0, 1, 0);
        rd(2'd0, 8'h22, "R10 no hw clear in slave");
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic [7:0] d;
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if ($urandom_range(0, 3) == 0) d[5] = 1'b0; else d[5] = 1'b1;
            step(a, ($urandom_range(0, 2) != 0), d, ($urandom_range(0, 1) == 1),
                 ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                 ($urandom_range(0, 1) == 1));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule